// File: doc/BRIEF.md
# Converter Bus Control and Output Formatter

This block is the host-facing control logic of a successive-approximation converter with a parallel result port. It turns a chip-enable, an active-low chip-select, a read/convert line, a byte-address bit and a word-format pin into two things. The first is a start command for the converter sequencer. The second is a read of the last finished result, placed on a 12-bit data bus with one output enable for each nibble. A busy output is held high while a conversion runs. After the sequencer reports completion, busy stays high for a further acquisition hold-off. Reads are already allowed during that hold-off, so the host can collect the data before busy drops.

A second operating style is selected by `solo_mode`. In that style only the read/convert line matters. Its falling edge starts a conversion, and while it is high the full 12-bit word is driven. The sequencer sits outside this block. The block gives it a one-cycle start pulse and a short-cycle flag, and takes back a done pulse and the result word. All outputs are registered. Each delay is a parameter counted in clock cycles.

Top module: `conv_bus_ctrl`

## Requirements
- R1: After reset, `busy`, `seq_start`, `dout_oe` and `dout` are all zero.
- R2: With `solo_mode` low, no conversion starts and no output is enabled unless `chip_en` is 1 and `chip_sel_n` is 0 in the same cycle.
- R3: With `solo_mode` low, a conversion is accepted when `chip_en`=1, `chip_sel_n`=0 and `rd_conv`=0 become true together while the block is idle. On the next cycle `seq_start` is high for exactly one cycle, and `seq_short` holds the value `byte_addr` had at that command (0 selects a 12-bit cycle, 1 selects an 8-bit cycle).
- R4: A selected read (`rd_conv`=1) with `word_fmt`=1 sets `dout_oe`=3'b111 and `dout` to the full result on the cycle after it is sampled. `dout_oe` bit 2 enables `dout[11:8]`, bit 1 enables `dout[7:4]` and bit 0 enables `dout[3:0]`.
- R5: A selected read with `word_fmt`=0 and `byte_addr`=0 sets `dout_oe`=3'b110 and puts result bits 11..4 on `dout[11:4]`, with `dout[3:0]`=0.
- R6: A selected read with `word_fmt`=0 and `byte_addr`=1 sets `dout_oe`=3'b110 and puts result bits 3..0 on `dout[11:8]`, with `dout[7:4]` forced to 0 and `dout[3:0]` disabled. Any disabled nibble drives 0.
- R7: `busy` rises exactly `RISE_CYC` cycles after the clock edge that accepts a start. It falls exactly `ACQ_CYC` cycles after the edge that samples `seq_done`.
- R8: Between an accepted start and the fall of `busy`, further convert commands are ignored. Until `seq_done` is seen, reads return `dout_oe`=0.
- R9: During the acquisition hold-off (after `seq_done`, while `busy` is still high), reads are served and return the new result.
- R10: The result is captured only on `seq_done`. Changes on `seq_result` at any other time do not alter read data.
- R11: With `solo_mode` high, `chip_en`, `chip_sel_n`, `byte_addr` and `word_fmt` have no effect. `rd_conv`=1 drives all 12 bits with `dout_oe`=3'b111. A falling edge of `rd_conv` starts a 12-bit conversion (`seq_short`=0), turns the outputs off on the next cycle, and raises `busy` `RISE_CYC` cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | 1 = read, 0 = convert; in solo mode the falling edge starts a conversion |
| byte_addr | input | 1 | Short-cycle select at convert; byte select at packed read |
| word_fmt | input | 1 | 1 = single 12-bit word, 0 = two packed bytes |
| solo_mode | input | 1 | Selects control by `rd_conv` alone |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| seq_result | input | W | Result word from the sequencer, valid with `seq_done` |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_short | output | 1 | Short (8-bit) cycle request, latched at start |
| busy | output | 1 | Conversion status |
| dout | output | W | Formatted result data |
| dout_oe | output | W/4 | Per-nibble output enables |

## Verification
The hardest situation to reach is the acquisition hold-off. In that window the status is still high and a new convert command must be dropped, yet a read has to return the fresh code. The bench reaches it by watching for the sequencer model's done pulse. On the next cycle it issues a read, and on the cycle after that a convert command. It then counts cycles to the exact edge where busy falls, and confirms the count of start pulses went up by one only. The same steps run again in solo mode, where the read comes from raising the read/convert line and the dropped command is a falling edge on it.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } cb_state_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WIDE = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rd_kind_e;

endpackage

// File: rtl/cb_cmd_decode.sv
module cb_cmd_decode
  import conv_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     chip_en,
  input  logic     chip_sel_n,
  input  logic     rd_conv,
  input  logic     byte_addr,
  input  logic     word_fmt,
  input  logic     solo_mode,
  input  logic     idle,
  input  logic     rd_open,
  output logic     start_req,
  output logic     start_short,
  output rd_kind_e rd_kind
);

  logic selected;
  logic conv_lvl;
  logic conv_lvl_q;
  logic rc_q;
  logic edge_full;
  logic edge_solo;

  assign selected  = chip_en & ~chip_sel_n;
  assign conv_lvl  = selected & ~rd_conv;
  assign edge_full = conv_lvl & ~conv_lvl_q;
  assign edge_solo = rc_q & ~rd_conv;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_lvl_q <= 1'b0;
      rc_q       <= 1'b0;
    end else begin
      conv_lvl_q <= conv_lvl;
      rc_q       <= rd_conv;
    end
  end

  // An edge that arrives while engaged is consumed, never queued.
  assign start_req   = idle & (solo_mode ? edge_solo : edge_full);
  assign start_short = solo_mode ? 1'b0 : byte_addr;

  always_comb begin
    rd_kind = RD_NONE;
    if (rd_open) begin
      if (solo_mode) begin
        if (rd_conv) rd_kind = RD_WIDE;
      end else if (selected && rd_conv) begin
        if (word_fmt)       rd_kind = RD_WIDE;
        else if (byte_addr) rd_kind = RD_LOW;
        else                rd_kind = RD_HIGH;
      end
    end
  end

endmodule

// File: rtl/cb_status_seq.sv
module cb_status_seq
  import conv_bus_pkg::*;
#(
  parameter int W        = 12,
  parameter int RISE_CYC = 4,
  parameter int ACQ_CYC  = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  input  logic         start_short,
  input  logic         seq_done,
  input  logic [W-1:0] seq_result,
  output logic         seq_start,
  output logic         seq_short,
  output logic         busy,
  output logic         idle,
  output logic         rd_open,
  output logic [W-1:0] result,
  output cb_state_e    state
);

  localparam int CNT_MAX = (RISE_CYC > ACQ_CYC) ? RISE_CYC : ACQ_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);

  cb_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic [W-1:0]  res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      res_q     <= '0;
      seq_start <= 1'b0;
      seq_short <= 1'b0;
      busy      <= 1'b0;
    end else begin
      seq_start <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_req) begin
            st_q      <= ST_ARM;
            cnt_q     <= '0;
            pend_q    <= 1'b0;
            seq_start <= 1'b1;
            seq_short <= start_short;
          end
        end
        ST_ARM: begin
          // A very fast sequencer may finish before status rises.
          if (seq_done) begin
            pend_q <= 1'b1;
            res_q  <= seq_result;
          end
          if (cnt_q == RISE_LAST) begin
            st_q  <= ST_CONV;
            busy  <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_CONV: begin
          if (seq_done || pend_q) begin
            if (seq_done) res_q <= seq_result;
            pend_q <= 1'b0;
            st_q   <= ST_HOLD;
            cnt_q  <= '0;
          end
        end
        ST_HOLD: begin
          if (cnt_q == ACQ_LAST) begin
            st_q <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign rd_open = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign result  = res_q;
  assign state   = st_q;

endmodule

// File: rtl/cb_out_fmt.sv
module cb_out_fmt
  import conv_bus_pkg::*;
#(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  rd_kind_e       rd_kind,
  input  logic [W-1:0]   result,
  output logic [W-1:0]   dout,
  output logic [W/4-1:0] dout_oe
);

  localparam int NIB = W / 4;

  logic [W-1:0]   d_next;
  logic [NIB-1:0] oe_next;

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    localparam bit IS_TOP  = (i == NIB - 1);
    localparam bit IS_NEXT = (i == NIB - 2);
    logic [3:0] nd;
    logic       ne;

    always_comb begin
      nd = 4'h0;
      ne = 1'b0;
      unique case (rd_kind)
        RD_WIDE: begin
          ne = 1'b1;
          nd = result[i*4 +: 4];
        end
        RD_HIGH: begin
          if (IS_TOP || IS_NEXT) begin
            ne = 1'b1;
            nd = result[i*4 +: 4];
          end
        end
        RD_LOW: begin
          if (IS_TOP) begin
            ne = 1'b1;
            nd = result[3:0];
          end else if (IS_NEXT) begin
            ne = 1'b1;
          end
        end
        default: begin
          ne = 1'b0;
        end
      endcase
    end

    assign d_next[i*4 +: 4] = nd;
    assign oe_next[i]       = ne;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= '0;
    end else begin
      dout    <= d_next;
      dout_oe <= oe_next;
    end
  end

endmodule

// File: rtl/conv_bus_ctrl.sv
module conv_bus_ctrl
  import conv_bus_pkg::*;
#(
  parameter int W        = 12,
  parameter int RISE_CYC = 4,
  parameter int ACQ_CYC  = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           chip_en,
  input  logic           chip_sel_n,
  input  logic           rd_conv,
  input  logic           byte_addr,
  input  logic           word_fmt,
  input  logic           solo_mode,
  input  logic           seq_done,
  input  logic [W-1:0]   seq_result,
  output logic           seq_start,
  output logic           seq_short,
  output logic           busy,
  output logic [W-1:0]   dout,
  output logic [W/4-1:0] dout_oe
);

  logic      start_req;
  logic      start_short;
  logic      idle;
  logic      rd_open;
  rd_kind_e  rd_kind;
  logic [W-1:0] res;
  cb_state_e st;

  cb_cmd_decode u_decode (
    .clk         (clk),
    .rst         (rst),
    .chip_en     (chip_en),
    .chip_sel_n  (chip_sel_n),
    .rd_conv     (rd_conv),
    .byte_addr   (byte_addr),
    .word_fmt    (word_fmt),
    .solo_mode   (solo_mode),
    .idle        (idle),
    .rd_open     (rd_open),
    .start_req   (start_req),
    .start_short (start_short),
    .rd_kind     (rd_kind)
  );

  cb_status_seq #(
    .W        (W),
    .RISE_CYC (RISE_CYC),
    .ACQ_CYC  (ACQ_CYC)
  ) u_status (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .start_short (start_short),
    .seq_done    (seq_done),
    .seq_result  (seq_result),
    .seq_start   (seq_start),
    .seq_short   (seq_short),
    .busy        (busy),
    .idle        (idle),
    .rd_open     (rd_open),
    .result      (res),
    .state       (st)
  );

  cb_out_fmt #(
    .W (W)
  ) u_fmt (
    .clk     (clk),
    .rst     (rst),
    .rd_kind (rd_kind),
    .result  (res),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

endmodule

// File: rtl/cb_checker.sv
module cb_checker
  import conv_bus_pkg::*;
#(
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           seq_start,
  input logic           seq_done,
  input logic           busy,
  input logic [W-1:0]   dout,
  input logic [W/4-1:0] dout_oe,
  input cb_state_e      st,
  input logic [W-1:0]   res
);

  localparam int NIB = W / 4;
  localparam logic [NIB-1:0] OE_ALL  = '1;
  localparam logic [NIB-1:0] OE_PAIR = OE_ALL & ~(OE_ALL >> 2);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);

  assert_start_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> !busy);

  assert_rise_held_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM) |-> !busy);

  assert_no_read_in_conv_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONV) |-> (dout_oe == '0));

  assert_oe_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (dout_oe == '0) || (dout_oe == OE_ALL) || (dout_oe == OE_PAIR));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !seq_done |=> $stable(res));

  for (genvar i = 0; i < NIB; i++) begin : g_off
    assert_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
      !dout_oe[i] |-> (dout[i*4 +: 4] == 4'h0));
  end

endmodule

bind conv_bus_ctrl cb_checker #(.W(W)) u_cb_checker (
  .clk       (clk),
  .rst       (rst),
  .seq_start (seq_start),
  .seq_done  (seq_done),
  .busy      (busy),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .st        (st),
  .res       (res)
);

// File: tb/conv_bus_ctrl_bench.sv
`timescale 1ns/1ps
module conv_bus_ctrl_bench;

  localparam int W    = 12;
  localparam int RISE = 4;
  localparam int ACQ  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, chip_sel_n = 1'b1, rd_conv = 1'b1;
  logic byte_addr = 1'b0, word_fmt = 1'b1, solo_mode = 1'b0;
  logic seq_done;
  logic [W-1:0] code_next = '0;
  logic seq_start, seq_short, busy;
  logic [W-1:0] dout;
  logic [2:0] dout_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int starts = 0;
  int sq_cnt = 0;
  bit finished = 1'b0;

  typedef struct {
    int          due;
    logic [2:0]  oe;
    logic [11:0] dat;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  conv_bus_ctrl #(.W(W), .RISE_CYC(RISE), .ACQ_CYC(ACQ)) u_conv_bus_ctrl (
    .clk(clk), .rst(rst), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .byte_addr(byte_addr), .word_fmt(word_fmt),
    .solo_mode(solo_mode), .seq_done(seq_done), .seq_result(code_next),
    .seq_start(seq_start), .seq_short(seq_short), .busy(busy),
    .dout(dout), .dout_oe(dout_oe)
  );

  // Sequencer model: 12 or 8 cycles after the start pulse, one done pulse.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      seq_done <= 1'b0;
      sq_cnt   <= 0;
    end else begin
      seq_done <= 1'b0;
      if (seq_start) begin
        sq_cnt <= seq_short ? 8 : 12;
        starts <= starts + 1;
      end else if (sq_cnt > 0) begin
        sq_cnt <= sq_cnt - 1;
        if (sq_cnt == 1) seq_done <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: the read sampled at the next edge.
  task automatic expect_rd(input logic [2:0] oe, input logic [11:0] dat, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.oe  = oe;
    e.dat = dat;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor side.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.due == cyc && dout_oe == e.oe && dout == e.dat, e.tag,
          {17'd0, dout_oe, dout}, {17'd0, e.oe, e.dat});
    end
  end

  task automatic run_conv(input bit solo, input bit sb, input logic [11:0] code);
    int base;
    base = starts;
    code_next = code;
    if (solo) rd_conv = 1'b0;
    else begin chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b0; byte_addr = sb; end
    expect_rd(3'b000, 12'h000, solo ? "R11 outputs off after falling edge" : "R8 outputs off at convert");
    @(negedge clk);
    chk(seq_start == 1'b1, "R3 start pulse", seq_start, 1);
    chk(seq_short == (solo ? 1'b0 : sb), "R3 R11 short flag latched", seq_short, solo ? 0 : sb);
    if (!solo) chip_en = 1'b0;
    repeat (RISE - 1) @(negedge clk);
    chk(busy == 1'b0, "R7 busy before rise delay", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, solo ? "R11 busy rise delay" : "R7 busy after rise delay", busy, 1);
    if (!solo) begin
      chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1; word_fmt = 1'b1;
      expect_rd(3'b000, 12'h000, "R8 read blocked during conversion");
      @(negedge clk);
      chip_en = 1'b0;
    end
    while (!seq_done) @(negedge clk);
    @(negedge clk);
    if (solo) rd_conv = 1'b1;
    else begin chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1; word_fmt = 1'b1; end
    expect_rd(3'b111, code, "R9 read during hold-off");
    chk(busy == 1'b1, "R9 busy still high in hold-off", busy, 1);
    @(negedge clk);
    if (solo) rd_conv = 1'b0;
    else begin chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b0; end
    @(negedge clk);
    if (!solo) chip_en = 1'b0;
    for (int k = 3; k < ACQ; k++) @(negedge clk);
    chk(busy == 1'b1, "R7 busy held through hold-off", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy falls after hold-off", busy, 0);
    repeat (RISE + 2) @(negedge clk);
    chk(starts == base + 1, "R8 convert during busy ignored", starts, base + 1);
    chk(busy == 1'b0, "R8 no restart after ignored command", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(seq_start == 1'b0, "R1 start after reset", seq_start, 0);
    chk(dout_oe == 3'b000 && dout == '0, "R1 outputs after reset", {dout_oe, dout}, 0);

    // R2: not selected
    chip_en = 1'b1; chip_sel_n = 1'b1; rd_conv = 1'b0;
    repeat (3) @(negedge clk);
    chip_en = 1'b0; chip_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(starts == 0, "R2 no start without both selects", starts, 0);
    chk(busy == 1'b0, "R2 busy stays low", busy, 0);
    chip_en = 1'b1; chip_sel_n = 1'b1; rd_conv = 1'b1;
    expect_rd(3'b000, 12'h000, "R2 read with chip_sel_n high");
    @(negedge clk);
    chip_en = 1'b0; chip_sel_n = 1'b0;
    expect_rd(3'b000, 12'h000, "R2 read with chip_en low");
    @(negedge clk);

    run_conv(1'b0, 1'b0, 12'hA5C);
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1; word_fmt = 1'b1;
    expect_rd(3'b111, 12'hA5C, "R4 word read");
    @(negedge clk);
    word_fmt = 1'b0; byte_addr = 1'b0;
    expect_rd(3'b110, 12'hA50, "R5 packed high byte");
    @(negedge clk);
    byte_addr = 1'b1;
    expect_rd(3'b110, 12'hC00, "R6 packed low nibble");
    @(negedge clk);
    chip_en = 1'b0;
    @(negedge clk);

    run_conv(1'b0, 1'b1, 12'h3B7);
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1; word_fmt = 1'b1;
    expect_rd(3'b111, 12'h3B7, "R4 word read after short cycle");
    @(negedge clk);
    word_fmt = 1'b0; byte_addr = 1'b1;
    expect_rd(3'b110, 12'h700, "R6 packed low nibble second code");
    @(negedge clk);
    chip_en = 1'b0;

    // R10: sequencer bus changes without done
    code_next = 12'hFFF;
    repeat (5) @(negedge clk);
    chip_en = 1'b1; word_fmt = 1'b1;
    expect_rd(3'b111, 12'h3B7, "R10 result unchanged without done");
    @(negedge clk);
    chip_en = 1'b0; chip_sel_n = 1'b1;
    @(negedge clk);

    // R11: stand-alone
    solo_mode = 1'b1; word_fmt = 1'b0; byte_addr = 1'b1; rd_conv = 1'b1;
    expect_rd(3'b111, 12'h3B7, "R11 solo read ignores other pins");
    @(negedge clk);
    run_conv(1'b1, 1'b0, 12'h5E7);
    rd_conv = 1'b1;
    expect_rd(3'b111, 12'h5E7, "R11 solo read of new code");
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R4 scoreboard drained", sbq.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule